// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Driver

This block is a digital model of a cascadable row-scan driver for an active-matrix display panel. It has up to 300 gate outputs. A start token taken from one end of the chip walks across the gate outputs, one row for each rising edge of a vertical shift clock. Each gate output is one logic bit: 1 stands for the on rail and 0 for the off rail.

A static direction pin sets the scan direction. It also decides which side of the chip receives the data, clock and enable signals and which side passes them on to the next chip in a cascade. Two mode pins cut the number of active outputs to 263 or 256. In those modes a block of middle channels is skipped by the shift chain and held off. Two overrides act on the outputs without any clock. The first is an active-high output enable that blanks every gate. The second is an active-low display-on input that drives every active gate on; it takes precedence over the output enable.

Top module: `gate_scan_driver`

## Requirements
- R1: A 1 on the active data input is captured into the first active stage on a rising edge of the shift clock. It then moves to the next active stage on each later rising edge. With output enable low and display-on high, `gate` shows the stage contents.
- R2: With `dir_up` = 1, the scan runs from gate[0] to gate[299] and the left-side pins (`data_l_in`, `sclk_l_in`, `oen_l_in`) are the inputs. With `dir_up` = 0, the scan runs from gate[299] down to gate[0] and the right-side pins are the inputs.
- R3: The cascade output is the data pin on the far side (`data_r_out` when scanning up, `data_l_out` when scanning down). It carries the last stage (gate[299] up, gate[0] down) and changes only on a falling edge of the shift clock. The data output on the input side stays 0.
- R4: The shift clock and the output enable on the input side appear unchanged, with no clocking, on the `sclk_*_out` and `oen_*_out` pins of the opposite side. The clock and enable outputs on the input side stay 0.
- R5: The channel count is set by `mode_sel` = {M1,M0}. 2'b11 and 2'b00 give 300 outputs. 2'b10 gives 263 outputs, with gate[132..168] inactive. 2'b01 gives 256 outputs, with gate[128..171] inactive. The token skips the inactive block and reaches the last channel after as many rising edges as there are active outputs.
- R6: Inactive channels always output 0, whatever the other inputs do.
- R7: While the input-side output enable is 1 (and display-on is high), every gate output is 0. No clock edge is involved.
- R8: While `disp_on_n` is 0, every active gate output is 1, whatever the stage contents and the output enable. While it is 0 the shift stages are cleared, so after release every output stays 0 until a new token is loaded.
- R9: The mode pins are taken into the internal mode register on a rising edge only when all shift stages are empty. A change made during a scan takes effect on the first rising edge after the chain has emptied.
- R10: While `rst_n` is 0, the stages and the cascade output are cleared without a clock, and the mode register returns to 300-output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_up | input | 1 | Scan direction and pin-side select, static |
| mode_sel | input | 2 | Channel-count select {M1,M0} |
| disp_on_n | input | 1 | Active-low all-on override |
| data_l_in | input | 1 | Left-side data input (start token when scanning up) |
| data_l_out | output | 1 | Left-side data output (cascade when scanning down) |
| data_r_in | input | 1 | Right-side data input (start token when scanning down) |
| data_r_out | output | 1 | Right-side data output (cascade when scanning up) |
| sclk_l_in | input | 1 | Left-side shift clock input |
| sclk_l_out | output | 1 | Left-side shift clock pass-through output |
| sclk_r_in | input | 1 | Right-side shift clock input |
| sclk_r_out | output | 1 | Right-side shift clock pass-through output |
| oen_l_in | input | 1 | Left-side output enable input, 1 blanks |
| oen_l_out | output | 1 | Left-side output enable pass-through output |
| oen_r_in | input | 1 | Right-side output enable input, 1 blanks |
| oen_r_out | output | 1 | Right-side output enable pass-through output |
| gate | output | 300 | Gate outputs, bit 0 is the first row |

## Verification
The assertions assume that only one token is in the chain at any time. They also assume that the direction pin, the output enable and the display-on input change only while the shift clock is low, never at one of its edges. The stimulus keeps to these limits. It loads a single token per scan and flushes it out before the next one. It moves the direction, the mode pins and the overrides only in the low phase of the clock. The random output-enable pulses are placed between edges.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

  typedef enum logic [1:0] {
    CH_256 = 2'b01,
    CH_263 = 2'b10,
    CH_300 = 2'b11
  } ch_mode_e;

  // zero-based bounds of the skipped middle blocks
  localparam int G263_LO = 132;
  localparam int G263_HI = 168;
  localparam int G256_LO = 128;
  localparam int G256_HI = 171;

  function automatic ch_mode_e norm_mode(input logic [1:0] pins);
    return (pins == 2'b00) ? CH_300 : ch_mode_e'(pins);
  endfunction

  function automatic logic chan_active(input ch_mode_e m, input int idx);
    logic in263, in256;
    in263 = (idx >= G263_LO) && (idx <= G263_HI);
    in256 = (idx >= G256_LO) && (idx <= G256_HI);
    return !((m == CH_263 && in263) || (m == CH_256 && in256));
  endfunction

endpackage

// File: rtl/gsd_route.sv
module gsd_route (
  input  logic dir_up,
  input  logic data_l_in,
  input  logic data_r_in,
  input  logic sclk_l_in,
  input  logic sclk_r_in,
  input  logic oen_l_in,
  input  logic oen_r_in,
  input  logic casc_q,
  output logic din,
  output logic shift_clk,
  output logic oen,
  output logic data_l_out,
  output logic data_r_out,
  output logic sclk_l_out,
  output logic sclk_r_out,
  output logic oen_l_out,
  output logic oen_r_out
);

  assign din       = dir_up ? data_l_in : data_r_in;
  assign shift_clk = dir_up ? sclk_l_in : sclk_r_in;
  assign oen       = dir_up ? oen_l_in  : oen_r_in;

  assign sclk_r_out = dir_up ? sclk_l_in : 1'b0;
  assign sclk_l_out = dir_up ? 1'b0      : sclk_r_in;
  assign oen_r_out  = dir_up ? oen_l_in  : 1'b0;
  assign oen_l_out  = dir_up ? 1'b0      : oen_r_in;
  assign data_r_out = dir_up ? casc_q    : 1'b0;
  assign data_l_out = dir_up ? 1'b0      : casc_q;

endmodule

// File: rtl/gsd_cfg.sv
module gsd_cfg
  import gsd_pkg::*;
(
  input  logic       shift_clk,
  input  logic       rst_n,
  input  logic       chain_idle,
  input  logic [1:0] mode_sel,
  output ch_mode_e   mode_q
);

  always_ff @(posedge shift_clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= CH_300;
    else if (chain_idle) mode_q <= norm_mode(mode_sel);
  end

endmodule

// File: rtl/gsd_chain.sv
module gsd_chain
  import gsd_pkg::*;
#(
  parameter int NCH = 300
) (
  input  logic           shift_clk,
  input  logic           clr_n,
  input  logic           dir_up,
  input  ch_mode_e       mode_q,
  input  logic           din,
  output logic [NCH-1:0] st,
  output logic           last_stage,
  output logic           chain_idle,
  output logic           casc_q
);

  localparam int LAST = NCH - 1;

  logic [NCH-1:0] nxt;

  for (genvar i = 0; i < NCH; i++) begin : g_stage
    logic from_up, from_dn;

    if (i == 0) begin : g_up_head
      assign from_up = din;
    end else if (i == G263_HI + 1) begin : g_up_j263
      assign from_up = (mode_q == CH_263) ? st[G263_LO-1] : st[i-1];
    end else if (i == G256_HI + 1) begin : g_up_j256
      assign from_up = (mode_q == CH_256) ? st[G256_LO-1] : st[i-1];
    end else begin : g_up_plain
      assign from_up = st[i-1];
    end

    if (i == LAST) begin : g_dn_head
      assign from_dn = din;
    end else if (i == G263_LO - 1) begin : g_dn_j263
      assign from_dn = (mode_q == CH_263) ? st[G263_HI+1] : st[i+1];
    end else if (i == G256_LO - 1) begin : g_dn_j256
      assign from_dn = (mode_q == CH_256) ? st[G256_HI+1] : st[i+1];
    end else begin : g_dn_plain
      assign from_dn = st[i+1];
    end

    assign nxt[i] = chan_active(mode_q, i) & (dir_up ? from_up : from_dn);
  end

  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) st <= '0;
    else        st <= nxt;
  end

  assign last_stage = dir_up ? st[LAST] : st[0];
  assign chain_idle = ~|st;

  always_ff @(negedge shift_clk or negedge clr_n) begin
    if (!clr_n) casc_q <= 1'b0;
    else        casc_q <= last_stage;
  end

endmodule

// File: rtl/gsd_outgate.sv
module gsd_outgate
  import gsd_pkg::*;
#(
  parameter int NCH = 300
) (
  input  ch_mode_e       mode_q,
  input  logic [NCH-1:0] st,
  input  logic           oen,
  input  logic           disp_on_n,
  output logic [NCH-1:0] gate
);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      gate[i] = chan_active(mode_q, i) & (~disp_on_n | (~oen & st[i]));
    end
  end

endmodule

// File: rtl/gate_scan_driver.sv
module gate_scan_driver
  import gsd_pkg::*;
#(
  parameter int NCH = 300
) (
  input  logic           rst_n,
  input  logic           dir_up,
  input  logic [1:0]     mode_sel,
  input  logic           disp_on_n,
  input  logic           data_l_in,
  output logic           data_l_out,
  input  logic           data_r_in,
  output logic           data_r_out,
  input  logic           sclk_l_in,
  output logic           sclk_l_out,
  input  logic           sclk_r_in,
  output logic           sclk_r_out,
  input  logic           oen_l_in,
  output logic           oen_l_out,
  input  logic           oen_r_in,
  output logic           oen_r_out,
  output logic [NCH-1:0] gate
);

  logic           din, shift_clk, oen, casc_q;
  logic           last_stage, chain_idle, clr_n;
  logic [NCH-1:0] st;
  ch_mode_e       mode_q;

  assign clr_n = rst_n & disp_on_n;

  gsd_route u_route (
    .dir_up(dir_up), .data_l_in(data_l_in), .data_r_in(data_r_in),
    .sclk_l_in(sclk_l_in), .sclk_r_in(sclk_r_in),
    .oen_l_in(oen_l_in), .oen_r_in(oen_r_in), .casc_q(casc_q),
    .din(din), .shift_clk(shift_clk), .oen(oen),
    .data_l_out(data_l_out), .data_r_out(data_r_out),
    .sclk_l_out(sclk_l_out), .sclk_r_out(sclk_r_out),
    .oen_l_out(oen_l_out), .oen_r_out(oen_r_out)
  );

  gsd_cfg u_cfg (
    .shift_clk(shift_clk), .rst_n(rst_n), .chain_idle(chain_idle),
    .mode_sel(mode_sel), .mode_q(mode_q)
  );

  gsd_chain #(.NCH(NCH)) u_chain (
    .shift_clk(shift_clk), .clr_n(clr_n), .dir_up(dir_up),
    .mode_q(mode_q), .din(din), .st(st), .last_stage(last_stage),
    .chain_idle(chain_idle), .casc_q(casc_q)
  );

  gsd_outgate #(.NCH(NCH)) u_outgate (
    .mode_q(mode_q), .st(st), .oen(oen), .disp_on_n(disp_on_n), .gate(gate)
  );

endmodule

// File: rtl/gsd_checker.sv
module gsd_checker
  import gsd_pkg::*;
#(
  parameter int NCH = 300
) (
  input logic           shift_clk,
  input logic           rst_n,
  input logic           disp_on_n,
  input logic           oen,
  input ch_mode_e       mode_q,
  input logic [NCH-1:0] st,
  input logic [NCH-1:0] gate,
  input logic           last_stage,
  input logic           casc_q
);

  logic [NCH-1:0] act_mask;
  always_comb begin
    for (int i = 0; i < NCH; i++) act_mask[i] = chan_active(mode_q, i);
  end

  AST_SINGLE_TOKEN: assert property (@(posedge shift_clk) disable iff (!rst_n)
    $onehot0(st)); // R1

  AST_CASC_ON_FALL: assert property (@(negedge shift_clk) disable iff (!rst_n || !disp_on_n)
    1'b1 |=> (casc_q == $past(last_stage))); // R3

  AST_GAP_HELD_OFF: assert property (@(posedge shift_clk) disable iff (!rst_n)
    (gate & ~act_mask) == '0); // R6

  AST_OE_BLANKS: assert property (@(posedge shift_clk) disable iff (!rst_n)
    (disp_on_n && oen) |-> (gate == '0)); // R7

  AST_DISPON_ALL_ON: assert property (@(posedge shift_clk) disable iff (!rst_n)
    !disp_on_n |-> (gate == act_mask)); // R8

  AST_EMPTY_AFTER_DISPON: assert property (@(posedge shift_clk) disable iff (!rst_n)
    $rose(disp_on_n) |-> (st == '0)); // R8

  AST_MODE_HELD_BUSY: assert property (@(posedge shift_clk) disable iff (!rst_n)
    (|st) |=> $stable(mode_q)); // R9

endmodule

bind gate_scan_driver gsd_checker #(.NCH(NCH)) u_chk (
  .shift_clk(shift_clk), .rst_n(rst_n), .disp_on_n(disp_on_n), .oen(oen),
  .mode_q(mode_q), .st(st), .gate(gate), .last_stage(last_stage),
  .casc_q(casc_q)
);

// File: tb/gate_scan_driver_tb.sv
module gate_scan_driver_tb;

  localparam int CLK_PERIOD = 20;
  localparam int Q = CLK_PERIOD / 4;
  localparam int NCH = 300;

  logic           rst_n, dir_up, disp_on_n, clk_v, dtok, oen_v;
  logic [1:0]     mode_sel;
  logic           data_l_out, data_r_out, sclk_l_out, sclk_r_out;
  logic           oen_l_out, oen_r_out;
  logic [NCH-1:0] gate;
  logic           casc_hi, pass_hi;
  int             checks = 0;
  int             errors = 0;
  bit             done = 0;

  gate_scan_driver #(.NCH(NCH)) u_dut (
    .rst_n(rst_n), .dir_up(dir_up), .mode_sel(mode_sel), .disp_on_n(disp_on_n),
    .data_l_in(dir_up ? dtok : 1'b0), .data_l_out(data_l_out),
    .data_r_in(dir_up ? 1'b0 : dtok), .data_r_out(data_r_out),
    .sclk_l_in(dir_up ? clk_v : 1'b0), .sclk_l_out(sclk_l_out),
    .sclk_r_in(dir_up ? 1'b0 : clk_v), .sclk_r_out(sclk_r_out),
    .oen_l_in(dir_up ? oen_v : 1'b0), .oen_l_out(oen_l_out),
    .oen_r_in(dir_up ? 1'b0 : oen_v), .oen_r_out(oen_r_out),
    .gate(gate)
  );

  function automatic int n_active(input logic [1:0] m);
    return (m == 2'b10) ? 263 : (m == 2'b01) ? 256 : 300;
  endfunction

  // k-th channel visited, in scan order
  function automatic int chan_of(input logic [1:0] m, input logic up, input int k);
    int ku, lo, len;
    ku  = up ? k : n_active(m) - 1 - k;
    lo  = (m == 2'b10) ? 132 : (m == 2'b01) ? 128 : NCH;
    len = (m == 2'b10) ? 37 : (m == 2'b01) ? 44 : 0;
    return (ku < lo) ? ku : ku + len;
  endfunction

  function automatic logic [NCH-1:0] one_at(input int p);
    logic [NCH-1:0] v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  function automatic logic [NCH-1:0] live_mask(input logic [1:0] m);
    logic [NCH-1:0] v;
    v = '0;
    for (int k = 0; k < n_active(m); k++) v[chan_of(m, 1'b1, k)] = 1'b1;
    return v;
  endfunction

  function automatic logic casc_pin();
    return dir_up ? data_r_out : data_l_out;
  endfunction

  function automatic logic near_pin();
    return dir_up ? data_l_out : data_r_out;
  endfunction

  task automatic check_vec(input string tag, input logic [NCH-1:0] act,
                           input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one shift-clock period; samples taken in the high phase
  task automatic step();
    clk_v = 1'b1;
    #Q;
    casc_hi = casc_pin();
    pass_hi = dir_up ? sclk_r_out : sclk_l_out;
    #Q;
    clk_v = 1'b0;
    #Q;
  endtask

  task automatic run_scan(input logic up, input logic [1:0] m, input bit rnd_oe);
    int n;
    n = n_active(m);
    dir_up = up;
    mode_sel = m;
    #Q;
    step();                     // idle edge: mode taken in (R9)
    dtok = 1'b1;
    step();
    dtok = 1'b0;
    check_bit("R4 clock passed to far side", pass_hi, 1'b1);
    check_bit("R4 input-side clock out low", dir_up ? sclk_l_out : sclk_r_out, 1'b0);
    for (int k = 0; k < n; k++) begin
      if (k > 0) step();
      if (rnd_oe && ($urandom % 8 == 0)) begin
        oen_v = 1'b1;
        #1;
        check_vec("R7 enable high blanks", gate, '0);
        check_bit("R4 enable passed", dir_up ? oen_r_out : oen_l_out, 1'b1);
        oen_v = 1'b0;
        #1;
      end
      check_vec("R1 R2 R5 token position", gate, one_at(chan_of(m, up, k)));
      check_bit("R3 near data out low", near_pin(), 1'b0);
      if (k == n - 1) begin
        check_bit("R3 cascade not yet high before fall", casc_hi, 1'b0);
        check_bit("R3 cascade high after fall", casc_pin(), 1'b1);
      end else begin
        check_bit("R3 cascade low", casc_pin(), 1'b0);
      end
    end
    step();
    check_vec("R1 token left chain", gate, '0);
    check_bit("R3 cascade held until fall", casc_hi, 1'b1);
    check_bit("R3 cascade low after fall", casc_pin(), 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd41));
    rst_n = 1'b0; dir_up = 1'b1; disp_on_n = 1'b1; clk_v = 1'b0;
    dtok = 1'b0; oen_v = 1'b0; mode_sel = 2'b11;
    #(2 * CLK_PERIOD);
    check_vec("R10 reset gates off", gate, '0);
    check_bit("R10 reset cascade low", data_r_out, 1'b0);
    rst_n = 1'b1;
    #Q;

    run_scan(1'b1, 2'b11, 1'b1);
    run_scan(1'b0, 2'b11, 1'b1);
    run_scan(1'b1, 2'b10, 1'b1);
    run_scan(1'b0, 2'b10, 1'b0);
    run_scan(1'b1, 2'b01, 1'b1);
    run_scan(1'b0, 2'b01, 1'b1);
    run_scan(1'b1, 2'b00, 1'b0);

    // display-on override in 263 mode, token mid-chain
    dir_up = 1'b1; mode_sel = 2'b10;
    #Q; step();
    dtok = 1'b1; step(); dtok = 1'b0;
    for (int k = 0; k < 9; k++) step();
    check_vec("R5 token at row 9", gate, one_at(9));
    oen_v = 1'b1; disp_on_n = 1'b0;
    #Q;
    check_vec("R8 R6 all active on, gap off", gate, live_mask(2'b10));
    oen_v = 1'b0; disp_on_n = 1'b1;
    #Q;
    check_vec("R8 chain empty after release", gate, '0);
    for (int k = 0; k < 3; k++) step();
    check_vec("R8 still empty after clocks", gate, '0);
    check_bit("R8 cascade low", data_r_out, 1'b0);

    // mode change during a scan waits for an empty chain
    mode_sel = 2'b11;
    #Q; step();
    dtok = 1'b1; step(); dtok = 1'b0;
    for (int k = 0; k < 4; k++) step();
    mode_sel = 2'b10;
    for (int k = 4; k < 140; k++) step();
    check_vec("R9 old mode kept mid-scan", gate, one_at(140));
    for (int k = 140; k < NCH; k++) step();
    disp_on_n = 1'b0;
    #Q;
    check_vec("R9 old mask before idle edge", gate, live_mask(2'b11));
    disp_on_n = 1'b1;
    #Q;
    step();
    disp_on_n = 1'b0;
    #Q;
    check_vec("R9 new mask after idle edge", gate, live_mask(2'b10));
    disp_on_n = 1'b1;
    #Q;

    // reset mid-scan
    dtok = 1'b1; step(); dtok = 1'b0;
    step();
    rst_n = 1'b0;
    #1;
    check_vec("R10 reset clears chain", gate, '0);
    rst_n = 1'b1;
    disp_on_n = 1'b0;
    #1;
    check_vec("R10 mode back to full count", gate, live_mask(2'b11));
    disp_on_n = 1'b1;
    #Q;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule